// File: doc/BRIEF.md
# Hard-Sectored Floppy Host Port

This block sits between a processor's I/O bus and a minimal floppy controller that works on hard-sectored media. It decodes four I/O ports. Each port has one function on a write and another on a read. The block holds the drive control register and drives the drive-select, step, direction and side lines from it. It also holds the two flags that gate the disk read and disk write paths.

The disk side is abstracted as a byte stream. Incoming bytes use a valid/ready handshake. A sync-detected strobe marks the sync byte. Outgoing bytes also use a valid/ready handshake. A sector-mark input comes from the index/sector sensor.

Reading or writing the data port, and reading the sync port, stall the processor. The block holds a wait line high until the disk side delivers or accepts a byte. If no byte ever arrives, the wait line stays high. Both flags are set by software. Hardware clears them on the next rising edge of the sector mark, which limits each transfer to one sector.

A motor idle timer is restarted by a motor-start pulse. When the timer runs out, the block flags idle. A short time later it turns the motor off and clears the drive control register.

Top module: `fdc_host_port`

## Requirements
- R1: After reset, `cpuWait`, `readGate`, `writeGate`, `motorOn`, `motorIdle`, `rdReady` and `wrValid` are 0, `ioRdata` is 00h and `drvSel` is 00.
- R2: Only `ioAddr[1:0]` selects the port function. `ioAddr[3:2]` are ignored, so each function answers at four aliased addresses.
- R3: A write to port 2 sets the read flag (`readGate`=1). A read of port 2 clears it and returns 00h on `ioRdata`.
- R4: A write to port 3 sets the write flag (`writeGate`=1). A read of port 3 leaves both flags unchanged.
- R5: A 0-to-1 edge on `sectorMark` clears both flags. A set strobe in the same cycle as that edge wins, and the flag stays set. A mark held high does not clear the flag again.
- R6: A read of port 0 raises `cpuWait` in the cycle after the strobe. `rdReady` is high only while the read flag is set. The byte is captured on the `rdValid`/`rdReady` handshake and appears on `ioRdata`, and `cpuWait` falls in the cycle after the handshake.
- R7: A read of port 1 waits for `syncHit` while the read flag is set, ignoring plain `rdValid`. It returns `rdByte` sampled with `syncHit` (a correct sync byte is FBh) and releases `cpuWait` in the next cycle.
- R8: A write to port 0 latches `ioWdata` onto `wrByte` and raises `cpuWait`. `wrValid` is high only while the write flag is set, and `cpuWait` falls in the cycle after the `wrValid`/`wrReady` handshake.
- R9: A write to port 1 loads the drive control register. `drvSel` is 01 when bits[1:0]=01 and 10 when they are 10; 00 and 11 select no drive. `stepPulse` is bit 4, `stepDir` is bit 5 and `sideSel` is bit 6.
- R10: Port strobes that arrive while `cpuWait` is high are ignored.
- R11: A `motorKick` pulse sets `motorOn` and restarts the idle count. `motorIdle` rises IDLE_CYC cycles after the last kick. After a further OFF_CYC cycles, `motorOn` falls and the drive control register clears to zero.
- R12: A data-port access whose flag is clear never completes: `cpuWait` stays high whatever the disk side offers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioStb | input | 1 | One-cycle port access strobe |
| ioWr | input | 1 | 1 = output (write), 0 = input (read) |
| ioAddr | input | ADDR_W | Port address within the block |
| ioWdata | input | DATA_W | Write data from the processor |
| ioRdata | output | DATA_W | Read data to the processor |
| cpuWait | output | 1 | Processor stall request |
| rdByte | input | DATA_W | Byte from the disk side |
| rdValid | input | 1 | Disk byte valid |
| rdReady | output | 1 | Block takes a disk byte |
| syncHit | input | 1 | Sync byte present on rdByte |
| wrByte | output | DATA_W | Byte to the disk side |
| wrValid | output | 1 | Byte offered to the disk side |
| wrReady | input | 1 | Disk side accepts the byte |
| sectorMark | input | 1 | Sector mark from the sensor |
| readGate | output | 1 | Disk read flag |
| writeGate | output | 1 | Disk write flag |
| motorKick | input | 1 | Motor start / retrigger pulse |
| motorOn | output | 1 | Motor enable |
| motorIdle | output | 1 | Motor idle timeout reached |
| drvSel | output | 2 | Drive select, one-hot or zero |
| stepPulse | output | 1 | Head step pulse |
| stepDir | output | 1 | Step direction / write precompensation |
| sideSel | output | 1 | Head side select |

## Verification
A software set of a flag and a rising sector mark can fall in the same clock cycle. The bench provokes this by driving the port-2 or port-3 write strobe on the same cycle that `sectorMark` first goes high. It then checks that the flag stays set, and that it is cleared only by the next separate rising edge. A second overlap is a port strobe that arrives while a stalled data-port read is still waiting. That strobe is judged ignored when the write flag, which it would have set, stays clear once the read completes.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RDATA,
    ST_RSYNC,
    ST_WDATA
  } busSt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCtl;
    logic clearCtl;
    logic capRd;
    logic zeroRd;
    logic loadWr;
  } hostStb_t;

  localparam logic [1:0] OFS_DATA  = 2'd0;
  localparam logic [1:0] OFS_SYNC  = 2'd1;
  localparam logic [1:0] OFS_READ  = 2'd2;
  localparam logic [1:0] OFS_WRITE = 2'd3;

endpackage

// File: rtl/fdc_host_ctrl.sv
module fdc_host_ctrl
  import fdc_host_pkg::*;
#(
  parameter int unsigned IDLE_CYC = 750_000_000,
  parameter int unsigned OFF_CYC  = 25_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioStb,
  input  logic       ioWr,
  input  logic [1:0] portOfs,
  input  logic       rdValid,
  input  logic       syncHit,
  input  logic       wrReady,
  input  logic       sectorMark,
  input  logic       motorKick,
  output hostStb_t   stb,
  output logic       cpuWait,
  output logic       rdReady,
  output logic       wrValid,
  output logic       readGate,
  output logic       writeGate,
  output logic       motorOn,
  output logic       motorIdle
);

  localparam int unsigned LIMIT = IDLE_CYC + OFF_CYC;
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LIMIT - 1);
  localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(IDLE_CYC);

  busSt_t state, stateNext;
  logic rdFlag, wrFlag, markQ, markRise;
  logic accept, setRd, clrRd, setWr;
  logic rdTake, syncTake, wrTake, offEvt;
  logic [CNT_W-1:0] idleCnt;

  assign accept   = ioStb && (state == ST_IDLE);
  assign setRd    = accept && ioWr && (portOfs == OFS_READ);
  assign clrRd    = accept && !ioWr && (portOfs == OFS_READ);
  assign setWr    = accept && ioWr && (portOfs == OFS_WRITE);
  assign markRise = sectorMark && !markQ;

  assign rdReady  = (state == ST_RDATA) && rdFlag;
  assign rdTake   = rdReady && rdValid;
  assign syncTake = (state == ST_RSYNC) && rdFlag && syncHit;
  assign wrValid  = (state == ST_WDATA) && wrFlag;
  assign wrTake   = wrValid && wrReady;

  assign offEvt    = motorOn && !motorKick && (idleCnt == LAST_CNT);
  assign motorIdle = motorOn && (idleCnt >= IDLE_CNT);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept && (portOfs == OFS_DATA))
                 stateNext = ioWr ? ST_WDATA : ST_RDATA;
               else if (accept && !ioWr && (portOfs == OFS_SYNC))
                 stateNext = ST_RSYNC;
      ST_RDATA: if (rdTake)   stateNext = ST_IDLE;
      ST_RSYNC: if (syncTake) stateNext = ST_IDLE;
      ST_WDATA: if (wrTake)   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    stb.loadCtl  = accept && ioWr && (portOfs == OFS_SYNC);
    stb.loadWr   = accept && ioWr && (portOfs == OFS_DATA);
    stb.zeroRd   = clrRd;
    stb.capRd    = rdTake || syncTake;
    stb.clearCtl = offEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cpuWait <= 1'b0;
      rdFlag  <= 1'b0;
      wrFlag  <= 1'b0;
      markQ   <= 1'b0;
    end else begin
      state   <= stateNext;
      cpuWait <= (stateNext != ST_IDLE);
      markQ   <= sectorMark;
      if (setRd)                   rdFlag <= 1'b1;
      else if (clrRd || markRise)  rdFlag <= 1'b0;
      if (setWr)                   wrFlag <= 1'b1;
      else if (markRise)           wrFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      motorOn <= 1'b0;
      idleCnt <= '0;
    end else if (motorKick) begin
      motorOn <= 1'b1;
      idleCnt <= '0;
    end else if (offEvt) begin
      motorOn <= 1'b0;
      idleCnt <= '0;
    end else if (motorOn) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign readGate  = rdFlag;
  assign writeGate = wrFlag;

  a_r5_mark_clears_rd: assert property (@(posedge clk) disable iff (!rstN)
    (markRise && !setRd) |=> !readGate);
  a_r5_mark_clears_wr: assert property (@(posedge clk) disable iff (!rstN)
    (markRise && !setWr) |=> !writeGate);
  a_r6_read_release: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady) |=> !cpuWait);
  a_r8_write_release: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |=> !cpuWait);
  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWait && ioStb && !markRise) |=> $stable(writeGate));
  a_r11_idle_before_off: assert property (@(posedge clk) disable iff (!rstN)
    $fell(motorOn) |-> $past(motorIdle));

endmodule

// File: rtl/fdc_host_dpath.sv
module fdc_host_dpath
  import fdc_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStb_t          stb,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic [DATA_W-1:0] rdByte,
  output logic [DATA_W-1:0] ioRdata,
  output logic [DATA_W-1:0] wrByte,
  output logic [1:0]        drvSel,
  output logic              stepPulse,
  output logic              stepDir,
  output logic              sideSel
);

  localparam int unsigned SEL_A_B = 0;
  localparam int unsigned SEL_B_B = 1;
  localparam int unsigned STEP_B  = 4;
  localparam int unsigned DIR_B   = 5;
  localparam int unsigned SIDE_B  = 6;

  logic [DATA_W-1:0] ctlReg, rdReg, wrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= '0;
      rdReg  <= '0;
      wrReg  <= '0;
    end else begin
      if (stb.clearCtl)     ctlReg <= '0;
      else if (stb.loadCtl) ctlReg <= ioWdata;
      if (stb.capRd)        rdReg  <= rdByte;
      else if (stb.zeroRd)  rdReg  <= '0;
      if (stb.loadWr)       wrReg  <= ioWdata;
    end
  end

  // Both select bits set means no drive selected
  assign drvSel    = {ctlReg[SEL_B_B] && !ctlReg[SEL_A_B],
                      ctlReg[SEL_A_B] && !ctlReg[SEL_B_B]};
  assign stepPulse = ctlReg[STEP_B];
  assign stepDir   = ctlReg[DIR_B];
  assign sideSel   = ctlReg[SIDE_B];
  assign ioRdata   = rdReg;
  assign wrByte    = wrReg;

  a_r9_load_visible: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadCtl && !stb.clearCtl) |=> (stepPulse == $past(ioWdata[STEP_B])));

endmodule

// File: rtl/fdc_host_port.sv
module fdc_host_port
  import fdc_host_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDLE_CYC = 750_000_000,
  parameter int unsigned OFF_CYC  = 25_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioStb,
  input  logic              ioWr,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  output logic              cpuWait,
  input  logic [DATA_W-1:0] rdByte,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic              syncHit,
  output logic [DATA_W-1:0] wrByte,
  output logic              wrValid,
  input  logic              wrReady,
  input  logic              sectorMark,
  output logic              readGate,
  output logic              writeGate,
  input  logic              motorKick,
  output logic              motorOn,
  output logic              motorIdle,
  output logic [1:0]        drvSel,
  output logic              stepPulse,
  output logic              stepDir,
  output logic              sideSel
);

  hostStb_t stb;
  logic [1:0] portOfs;

  // Upper address bits are deliberately left undecoded (aliasing)
  assign portOfs = ioAddr[1:0];

  fdc_host_ctrl #(.IDLE_CYC(IDLE_CYC), .OFF_CYC(OFF_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioStb(ioStb), .ioWr(ioWr), .portOfs(portOfs),
    .rdValid(rdValid), .syncHit(syncHit), .wrReady(wrReady),
    .sectorMark(sectorMark), .motorKick(motorKick), .stb(stb),
    .cpuWait(cpuWait), .rdReady(rdReady), .wrValid(wrValid),
    .readGate(readGate), .writeGate(writeGate),
    .motorOn(motorOn), .motorIdle(motorIdle)
  );

  fdc_host_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .ioWdata(ioWdata), .rdByte(rdByte),
    .ioRdata(ioRdata), .wrByte(wrByte), .drvSel(drvSel),
    .stepPulse(stepPulse), .stepDir(stepDir), .sideSel(sideSel)
  );

endmodule

// File: tb/fdc_host_port_tb.sv
module fdc_host_port_tb;

  localparam int IDLE = 20;
  localparam int OFF  = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic ioStb = 0, ioWr = 0;
  logic [3:0] ioAddr = 0;
  logic [7:0] ioWdata = 0, rdByte = 0;
  logic rdValid = 0, syncHit = 0, wrReady = 0, sectorMark = 0, motorKick = 0;
  logic [7:0] ioRdata, wrByte;
  logic cpuWait, rdReady, wrValid, readGate, writeGate, motorOn, motorIdle;
  logic [1:0] drvSel;
  logic stepPulse, stepDir, sideSel;
  int nChecks = 0, nErr = 0, cycles = 0;

  always #2 clk = ~clk;

  fdc_host_port #(.IDLE_CYC(IDLE), .OFF_CYC(OFF)) u_dut (
    .clk(clk), .rstN(rstN), .ioStb(ioStb), .ioWr(ioWr), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .cpuWait(cpuWait),
    .rdByte(rdByte), .rdValid(rdValid), .rdReady(rdReady), .syncHit(syncHit),
    .wrByte(wrByte), .wrValid(wrValid), .wrReady(wrReady),
    .sectorMark(sectorMark), .readGate(readGate), .writeGate(writeGate),
    .motorKick(motorKick), .motorOn(motorOn), .motorIdle(motorIdle),
    .drvSel(drvSel), .stepPulse(stepPulse), .stepDir(stepDir), .sideSel(sideSel)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nErr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ioAccess(input logic wr, input logic [3:0] a, input logic [7:0] d);
    ioStb = 1; ioWr = wr; ioAddr = a; ioWdata = d;
    @(negedge clk);
    ioStb = 0;
  endtask

  task automatic doReset();
    rstN = 0; tick(3); rstN = 1; tick(1);
  endtask

  task automatic markPulse();
    sectorMark = 1; tick(1); sectorMark = 0; tick(1);
  endtask

  initial begin
    doReset();
    // R1 reset state
    chk("R1 wait", cpuWait, 0);   chk("R1 rgate", readGate, 0);
    chk("R1 wgate", writeGate, 0); chk("R1 motor", motorOn, 0);
    chk("R1 idle", motorIdle, 0); chk("R1 rdata", ioRdata, 0);
    chk("R1 sel", drvSel, 0);     chk("R1 rdy", rdReady, 0);
    chk("R1 wval", wrValid, 0);

    // R9 sweep of every control value across aliases (R2)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      logic [1:0] es;
      b = 8'(v);
      es = (b[1:0] == 2'b01) ? 2'b01 : (b[1:0] == 2'b10) ? 2'b10 : 2'b00;
      ioAccess(1, {b[3:2], 2'b01}, b);
      chk("R9 drvSel", drvSel, es);
      chk("R9 step", stepPulse, b[4]);
      chk("R9 dir", stepDir, b[5]);
      chk("R9 side", sideSel, b[6]);
    end

    // R2/R3/R4 flag ports at every alias
    for (int a = 0; a < 16; a++) begin
      logic [3:0] ad;
      ad = 4'(a);
      if (ad[1:0] == 2'd2) begin
        ioAccess(1, ad, 8'hFF);
        chk("R3 set rd", readGate, 1);
        ioAccess(0, ad, 8'h00);
        chk("R3 clr rd", readGate, 0);
        chk("R3 rdata 00", ioRdata, 0);
      end else if (ad[1:0] == 2'd3) begin
        ioAccess(1, ad, 8'h00);
        chk("R4 set wr", writeGate, 1);
        ioAccess(0, ad, 8'h00);
        chk("R4 read noop", writeGate, 1);
        chk("R4 read noop rd", readGate, 0);
        markPulse();
        chk("R5 mark clr wr", writeGate, 0);
      end
    end

    // R6 data read
    ioAccess(1, 4'h6, 0);
    ioAccess(0, 4'h4, 0);
    chk("R6 wait up", cpuWait, 1);
    chk("R6 ready", rdReady, 1);
    tick(3);
    chk("R6 still wait", cpuWait, 1);
    rdValid = 1; rdByte = 8'hA5; tick(1); rdValid = 0;
    chk("R6 released", cpuWait, 0);
    chk("R6 byte", ioRdata, 8'hA5);
    chk("R6 ready low", rdReady, 0);

    // R10 strobe during stall ignored
    ioAccess(0, 4'h0, 0);
    ioAccess(1, 4'h3, 0);
    rdValid = 1; rdByte = 8'h3C; tick(1); rdValid = 0;
    chk("R10 byte", ioRdata, 8'h3C);
    chk("R10 wr flag untouched", writeGate, 0);
    chk("R10 wait", cpuWait, 0);

    // R7 sync read
    ioAccess(0, 4'h9, 0);
    rdValid = 1; rdByte = 8'h11; tick(2);
    chk("R7 no sync yet", cpuWait, 1);
    syncHit = 1; rdByte = 8'hFB; tick(1); syncHit = 0; rdValid = 0;
    chk("R7 sync byte", ioRdata, 8'hFB);
    chk("R7 released", cpuWait, 0);

    // R8 data write
    ioAccess(1, 4'h7, 0);
    ioAccess(1, 4'h8, 8'h5E);
    chk("R8 wait", cpuWait, 1);
    chk("R8 valid", wrValid, 1);
    chk("R8 byte", wrByte, 8'h5E);
    tick(2);
    chk("R8 hold", cpuWait, 1);
    wrReady = 1; tick(1); wrReady = 0;
    chk("R8 released", cpuWait, 0);
    chk("R8 valid low", wrValid, 0);

    // R12 write with flag clear never completes
    markPulse();
    ioAccess(1, 4'h0, 8'h77);
    wrReady = 1; tick(4);
    chk("R12 wr stuck", cpuWait, 1);
    chk("R12 no valid", wrValid, 0);
    wrReady = 0;
    doReset();
    chk("R1 reset clears stall", cpuWait, 0);

    // R5 set and mark edge in the same cycle
    ioStb = 1; ioWr = 1; ioAddr = 4'h2; sectorMark = 1; tick(1); ioStb = 0;
    chk("R5 set wins rd", readGate, 1);
    tick(2);
    chk("R5 held mark no clr", readGate, 1);
    sectorMark = 0; tick(1); sectorMark = 1; tick(1);
    chk("R5 next edge clr", readGate, 0);
    sectorMark = 0; tick(1);
    ioStb = 1; ioWr = 1; ioAddr = 4'hF; sectorMark = 1; tick(1); ioStb = 0;
    chk("R5 set wins wr", writeGate, 1);
    sectorMark = 0; tick(1); markPulse();
    chk("R5 wr clr", writeGate, 0);

    // R11 motor timeout
    ioAccess(1, 4'h1, 8'h71);
    motorKick = 1; tick(1); motorKick = 0;
    chk("R11 on", motorOn, 1);
    chk("R11 not idle", motorIdle, 0);
    tick(IDLE - 1);
    chk("R11 before idle", motorIdle, 0);
    tick(1);
    chk("R11 idle", motorIdle, 1);
    chk("R11 still on", motorOn, 1);
    tick(OFF - 1);
    chk("R11 on before off", motorOn, 1);
    chk("R11 ctl kept", drvSel, 2'b01);
    tick(1);
    chk("R11 off", motorOn, 0);
    chk("R11 ctl cleared sel", drvSel, 0);
    chk("R11 ctl cleared step", stepPulse, 0);
    chk("R11 ctl cleared side", sideSel, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule